// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block serves one-word read and write requests against an SDRAM device split into two address regions. For each accepted request it issues activate, then a read or write, then precharge on the SDRAM command pins. The gaps between these commands come from a 2-bit latency code held for each region, so one device can sit behind slow and fast settings without changing the logic.

Each region has a base address, a mask, a latency code, a port-size code, a valid bit and a write-protect bit. An access that matches no valid region, or a write that lands on a protected region, finishes straight away with an error flag and issues no SDRAM command. The requester holds its request until a one-cycle ready strobe, which comes in the precharge cycle of a good access or in the cycle after acceptance of a refused one.

Top module: `sdram_seq`

## Requirements
- R1: A region matches when `((addr ^ base) & ~mask) == 0` and its valid bit is set. A region whose valid bit is clear is never selected. Its chip select stays high and the access ends in error unless another region matches.
- R2: When both regions match, region 0 is used, including for the write-protect decision.
- R3: A good access drives exactly three commands on the selected region's chip select, in this order: activate, read or write, precharge. Encoding on (ras_n, cas_n, we_n): activate 011, read 101, write 100, precharge 010, idle 111. The row is `addr[COL_W +: ROW_W]` on activate, the column is `addr[COL_W-1:0]` on read or write, and no other chip select goes low.
- R4: The read or write command comes k clocks after activate, where k = 1, 2, 3 for latency codes 0, 1 and 2 or 3.
- R5: Read data is sampled k clocks after the read command and appears on `req_rdata_o` while `req_ready_o` is high. Ready lasts one cycle and coincides with precharge.
- R6: Precharge comes at the later of 2k clocks after activate and one clock after the last data cycle. The last data cycle is the write command cycle for writes and the read sample cycle for reads.
- R7: The next activate comes at least k clocks after the previous precharge, where k is from the previous access's latency code.
- R8: A write that selects a region with its write-protect bit set returns ready with `req_err_o` high, issues no command, and leaves the stored data unchanged.
- R9: An access that matches no valid region returns ready with `req_err_o` high and issues no command.
- R10: Port-size code 0 enables all four byte lanes, code 1 enables lane 0, code 2 enables lanes 0 and 1, and code 3 acts as code 0. Disabled lanes are masked to zero in read data.
- R11: After reset every chip select and command pin is high, and ready, error and data output enable are low.
- R12: `sd_dq_oe_o` is high only in the write command cycle, with the request's write data on `sd_dq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request pending, held until ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request byte address |
| req_wdata_i | input | DW | Write data |
| req_ready_o | output | 1 | One-cycle completion strobe |
| req_err_o | output | 1 | Completion refused (with ready) |
| req_rdata_o | output | DW | Read data, valid with ready |
| rgn_base_i | input | N_REG*AW | Base address per region |
| rgn_mask_i | input | N_REG*AW | Don't-care address bits per region |
| rgn_lat_i | input | N_REG*2 | Latency code per region |
| rgn_psize_i | input | N_REG*2 | Port-size code per region |
| rgn_valid_i | input | N_REG | Region enable |
| rgn_wprot_i | input | N_REG | Region write protect |
| sd_cs_no | output | N_REG | Chip select per region, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_addr_o | output | SA_W | Row or column address |
| sd_dq_o | output | DW | Write data to device |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_be_o | output | DW/8 | Byte lane enables |
| sd_dq_i | input | DW | Read data from device |

## Verification
The hardest condition to create is the precharge-to-activate spacing at its minimum. It needs a new request waiting in the very cycle the sequencer goes idle, right after an access whose latency differs from the next one. The bench presents each request on the edge after the previous ready and reconfigures latency codes between accesses, so tight spacing occurs across every latency pair. Overlapping regions with region 0 protected test that priority is applied before protection. Off-cycle read-bus noise means a read sampled one clock early or late returns wrong data.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int TC_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ERR} st_e;
  typedef enum logic [2:0] {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE} cmd_e;

  typedef struct packed {
    logic [2:0] trcd;
    logic [2:0] tcasl;
    logic [2:0] tras;
    logic [2:0] trp;
  } gaps_t;

  function automatic gaps_t lat_gaps(logic [1:0] code);
    gaps_t g;
    case (code)
      2'd0:    g = '{trcd: 3'd1, tcasl: 3'd1, tras: 3'd2, trp: 3'd1};
      2'd1:    g = '{trcd: 3'd2, tcasl: 3'd2, tras: 3'd4, trp: 3'd2};
      default: g = '{trcd: 3'd3, tcasl: 3'd3, tras: 3'd6, trp: 3'd3};
    endcase
    return g;
  endfunction
endpackage

// File: rtl/sdram_seq_match.sv
module sdram_seq_match #(
  parameter int AW    = 24,
  parameter int N_REG = 2,
  parameter int SEL_W = 1
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [N_REG*AW-1:0] base_i,
  input  logic [N_REG*AW-1:0] mask_i,
  input  logic [N_REG-1:0]    valid_i,
  output logic                hit_o,
  output logic [SEL_W-1:0]    sel_o
);
  logic [N_REG-1:0] hit_vec;

  for (genvar g = 0; g < N_REG; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] &&
      (((addr_i ^ base_i[g*AW +: AW]) & ~mask_i[g*AW +: AW]) == '0);
  end

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_o = SEL_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/sdram_seq_timing.sv
module sdram_seq_timing
  import sdram_seq_pkg::*;
(
  input  logic [1:0]      lat_i,
  input  logic            wr_i,
  output logic [TC_W-1:0] cmd_at_o,
  output logic [TC_W-1:0] data_at_o,
  output logic [TC_W-1:0] pre_at_o,
  output logic [TC_W-1:0] last_at_o
);
  gaps_t g;
  logic [TC_W-1:0] rcd, cl, ras_t, rp, last_dat, after_dat;

  assign g        = lat_gaps(lat_i);
  assign rcd      = TC_W'(g.trcd);
  assign cl       = TC_W'(g.tcasl);
  assign ras_t    = TC_W'(g.tras);
  assign rp       = TC_W'(g.trp);

  assign cmd_at_o  = rcd;
  assign data_at_o = rcd + cl;
  assign last_dat  = wr_i ? rcd : rcd + cl;
  assign after_dat = last_dat + TC_W'(1);
  assign pre_at_o  = (ras_t > after_dat) ? ras_t : after_dat;
  // idle cycle plus accept cycle already give two clocks of spacing
  assign last_at_o = pre_at_o + ((rp > TC_W'(2)) ? rp - TC_W'(2) : TC_W'(0));
endmodule

// File: rtl/sdram_seq_lanes.sv
module sdram_seq_lanes #(
  parameter int DW   = 32,
  parameter int BE_W = DW / 8
) (
  input  logic [1:0]      psize_i,
  output logic [BE_W-1:0] be_o,
  output logic [DW-1:0]   mask_o
);
  int n_on;

  always_comb begin
    case (psize_i)
      2'd1:    n_on = 1;
      2'd2:    n_on = 2;
      default: n_on = BE_W;
    endcase
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign be_o[g]          = (g < n_on);
    assign mask_o[g*8 +: 8] = {8{be_o[g]}};
  end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int ROW_W = 11,
  parameter int COL_W = 9,
  parameter int N_REG = 2,
  localparam int SA_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BE_W = DW / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [AW-1:0]       req_addr_i,
  input  logic [DW-1:0]       req_wdata_i,
  output logic                req_ready_o,
  output logic                req_err_o,
  output logic [DW-1:0]       req_rdata_o,
  input  logic [N_REG*AW-1:0] rgn_base_i,
  input  logic [N_REG*AW-1:0] rgn_mask_i,
  input  logic [N_REG*2-1:0]  rgn_lat_i,
  input  logic [N_REG*2-1:0]  rgn_psize_i,
  input  logic [N_REG-1:0]    rgn_valid_i,
  input  logic [N_REG-1:0]    rgn_wprot_i,
  output logic [N_REG-1:0]    sd_cs_no,
  output logic                sd_ras_no,
  output logic                sd_cas_no,
  output logic                sd_we_no,
  output logic [SA_W-1:0]     sd_addr_o,
  output logic [DW-1:0]       sd_dq_o,
  output logic                sd_dq_oe_o,
  output logic [BE_W-1:0]     sd_be_o,
  input  logic [DW-1:0]       sd_dq_i
);
  localparam int SEL_W = (N_REG > 1) ? $clog2(N_REG) : 1;

  st_e              st_q;
  cmd_e             cmd;
  logic [TC_W-1:0]  tcnt_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic [SEL_W-1:0] sel_q, sel;
  logic [1:0]       lat_q, psize_q;
  logic             hit, refuse;
  logic [TC_W-1:0]  cmd_at, data_at, pre_at, last_at;
  logic [BE_W-1:0]  be;
  logic [DW-1:0]    lane_mask;

  sdram_seq_match #(.AW(AW), .N_REG(N_REG), .SEL_W(SEL_W)) u_match (
    .addr_i (req_addr_i),
    .base_i (rgn_base_i),
    .mask_i (rgn_mask_i),
    .valid_i(rgn_valid_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  sdram_seq_timing u_timing (
    .lat_i    (lat_q),
    .wr_i     (wr_q),
    .cmd_at_o (cmd_at),
    .data_at_o(data_at),
    .pre_at_o (pre_at),
    .last_at_o(last_at)
  );

  sdram_seq_lanes #(.DW(DW), .BE_W(BE_W)) u_lanes (
    .psize_i(psize_q),
    .be_o   (be),
    .mask_o (lane_mask)
  );

  assign refuse = !hit || (req_write_i && rgn_wprot_i[sel]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      sel_q   <= '0;
      lat_q   <= '0;
      psize_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          tcnt_q <= '0;
          if (req_valid_i) begin
            if (refuse) begin
              st_q <= ST_ERR;
            end else begin
              st_q    <= ST_RUN;
              row_q   <= req_addr_i[COL_W +: ROW_W];
              col_q   <= req_addr_i[COL_W-1:0];
              wr_q    <= req_write_i;
              wdata_q <= req_wdata_i;
              sel_q   <= sel;
              lat_q   <= rgn_lat_i[sel*2 +: 2];
              psize_q <= rgn_psize_i[sel*2 +: 2];
            end
          end
        end
        ST_RUN: begin
          if (!wr_q && tcnt_q == data_at) rdata_q <= sd_dq_i & lane_mask;
          if (tcnt_q == last_at) begin
            st_q   <= ST_IDLE;
            tcnt_q <= '0;
          end else begin
            tcnt_q <= tcnt_q + TC_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    if (st_q == ST_RUN) begin
      if (tcnt_q == '0)         cmd = CMD_ACT;
      else if (tcnt_q == cmd_at) cmd = wr_q ? CMD_WR : CMD_RD;
      else if (tcnt_q == pre_at) cmd = CMD_PRE;
    end
  end

  always_comb begin
    {sd_ras_no, sd_cas_no, sd_we_no} = 3'b111;
    sd_addr_o = '0;
    case (cmd)
      CMD_ACT: begin
        {sd_ras_no, sd_cas_no, sd_we_no} = 3'b011;
        sd_addr_o = SA_W'(row_q);
      end
      CMD_RD: begin
        {sd_ras_no, sd_cas_no, sd_we_no} = 3'b101;
        sd_addr_o = SA_W'(col_q);
      end
      CMD_WR: begin
        {sd_ras_no, sd_cas_no, sd_we_no} = 3'b100;
        sd_addr_o = SA_W'(col_q);
      end
      CMD_PRE: {sd_ras_no, sd_cas_no, sd_we_no} = 3'b010;
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_cs
    assign sd_cs_no[g] = !((cmd != CMD_NOP) && (sel_q == SEL_W'(g)));
  end

  assign sd_dq_oe_o  = (cmd == CMD_WR);
  assign sd_dq_o     = sd_dq_oe_o ? wdata_q : '0;
  assign sd_be_o     = (st_q == ST_RUN) ? be : '0;
  assign req_ready_o = (st_q == ST_ERR) || ((st_q == ST_RUN) && (tcnt_q == pre_at));
  assign req_err_o   = (st_q == ST_ERR);
  assign req_rdata_o = rdata_q;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int N_REG = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [N_REG-1:0] cs_n,
  input logic [N_REG-1:0] wprot,
  input logic [N_REG-1:0] vld,
  input logic             dq_oe,
  input logic             ready,
  input logic             err,
  input logic [1:0]       lat
);
  logic any_cs, is_act, is_rd, is_wr, is_pre;
  logic [3:0] since_act_q, since_pre_q;
  logic [2:0] trp_q;
  logic seen_pre_q;
  gaps_t g;

  assign g      = lat_gaps(lat);
  assign any_cs = ~&cs_n;
  assign is_act = any_cs && {ras_n, cas_n, we_n} == 3'b011;
  assign is_rd  = any_cs && {ras_n, cas_n, we_n} == 3'b101;
  assign is_wr  = any_cs && {ras_n, cas_n, we_n} == 3'b100;
  assign is_pre = any_cs && {ras_n, cas_n, we_n} == 3'b010;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= '0;
      since_pre_q <= '0;
      trp_q       <= '0;
      seen_pre_q  <= 1'b0;
    end else begin
      since_act_q <= is_act ? 4'd1 : ((since_act_q == 4'hF) ? 4'hF : since_act_q + 4'd1);
      since_pre_q <= is_pre ? 4'd1 : ((since_pre_q == 4'hF) ? 4'hF : since_pre_q + 4'd1);
      if (is_pre) begin
        seen_pre_q <= 1'b1;
        trp_q      <= g.trp;
      end
    end
  end

  p_one_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(~cs_n));
  p_valid_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) (~cs_n & ~vld) == '0);
  p_trcd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd || is_wr) |-> since_act_q == 4'(g.trcd));
  p_ready_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) ready |=> !ready);
  p_tras_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> since_act_q >= 4'(g.tras));
  p_trp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && seen_pre_q) |-> since_pre_q >= 4'(trp_q));
  p_no_wr_prot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |-> (~cs_n & wprot) == '0);
  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> (ready && !any_cs));
  p_oe_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni) dq_oe |-> is_wr);
endmodule

bind sdram_seq sdram_seq_chk #(.N_REG(N_REG)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ras_n (sd_ras_no),
  .cas_n (sd_cas_no),
  .we_n  (sd_we_no),
  .cs_n  (sd_cs_no),
  .wprot (rgn_wprot_i),
  .vld   (rgn_valid_i),
  .dq_oe (sd_dq_oe_o),
  .ready (req_ready_o),
  .err   (req_err_o),
  .lat   (lat_q)
);

// File: tb/sdram_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0, sd_dq_i = '0;
  logic req_ready_o, req_err_o;
  logic [31:0] req_rdata_o, sd_dq_o;
  logic [23:0] base [2], mask [2];
  logic [1:0] lat [2], ps [2];
  logic [1:0] vld, wp;
  logic [1:0] sd_cs_no;
  logic sd_ras_no, sd_cas_no, sd_we_no, sd_dq_oe_o;
  logic [10:0] sd_addr_o;
  logic [3:0] sd_be_o;

  sdram_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready_o), .req_err_o(req_err_o),
    .req_rdata_o(req_rdata_o),
    .rgn_base_i({base[1], base[0]}), .rgn_mask_i({mask[1], mask[0]}),
    .rgn_lat_i({lat[1], lat[0]}), .rgn_psize_i({ps[1], ps[0]}),
    .rgn_valid_i(vld), .rgn_wprot_i(wp),
    .sd_cs_no(sd_cs_no), .sd_ras_no(sd_ras_no), .sd_cas_no(sd_cas_no),
    .sd_we_no(sd_we_no), .sd_addr_o(sd_addr_o), .sd_dq_o(sd_dq_o),
    .sd_dq_oe_o(sd_dq_oe_o), .sd_be_o(sd_be_o), .sd_dq_i(sd_dq_i)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit [31:0] mem_model [int];
  bit [31:0] ref_mem [int];
  int n_cmd = 0, act_cyc, cmd_cyc, pre_cyc, act_cs, oe_bad = 0;
  logic [10:0] act_row, open_row [2];
  logic [8:0] cmd_col;
  logic [31:0] wr_dq;
  logic wr_oe;
  logic [3:0] be_seen;
  int rd_cd = 0, rd_key;
  int prev_pre = 0, prev_trp = 0;
  bit have_prev = 0;

  function automatic int kgap(input logic [1:0] l);
    return (l == 2'd0) ? 1 : (l == 2'd1) ? 2 : 3;
  endfunction
  function automatic logic [31:0] lmask(input logic [1:0] p);
    return (p == 2'd1) ? 32'h0000_00FF : (p == 2'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [3:0] lbe(input logic [1:0] p);
    return (p == 2'd1) ? 4'h1 : (p == 2'd2) ? 4'h3 : 4'hF;
  endfunction
  // selected region, -1 when refused; prot flags protection, both flags overlap
  function automatic int exp_region(input logic [23:0] a, input bit w, output bit prot, output bit both);
    int sel = -1;
    int nh = 0;
    prot = 0;
    for (int i = 0; i < 2; i++) begin
      if (vld[i] && (((a ^ base[i]) & ~mask[i]) == 24'h0)) begin
        nh++;
        if (sel < 0) sel = i;
      end
    end
    both = (nh == 2);
    if (sel >= 0 && w && wp[sel]) begin prot = 1; sel = -1; end
    return sel;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // SDRAM pin monitor and device model
  always @(negedge clk) begin
    logic [2:0] c;
    int ci, k;
    logic [31:0] v;
    cyc++;
    sd_dq_i = 32'hA5C3_0000 ^ cyc;
    if (rd_cd > 0) begin
      rd_cd--;
      if (rd_cd == 0) sd_dq_i = mem_model[rd_key];
    end
    if (sd_dq_oe_o && !(!(&sd_cs_no) && {sd_ras_no, sd_cas_no, sd_we_no} == 3'b100)) oe_bad++;
    if (!(&sd_cs_no)) begin
      c  = {sd_ras_no, sd_cas_no, sd_we_no};
      ci = !sd_cs_no[0] ? 0 : 1;
      n_cmd++;
      case (c)
        3'b011: begin act_cyc = cyc; act_cs = ci; open_row[ci] = sd_addr_o; act_row = sd_addr_o; end
        3'b101: begin
          cmd_cyc = cyc; cmd_col = sd_addr_o[8:0]; be_seen = sd_be_o;
          rd_key  = (ci << 20) | (int'(open_row[ci]) << 9) | int'(sd_addr_o[8:0]);
          rd_cd   = kgap(lat[ci]);
        end
        3'b100: begin
          cmd_cyc = cyc; cmd_col = sd_addr_o[8:0]; be_seen = sd_be_o;
          wr_dq = sd_dq_o; wr_oe = sd_dq_oe_o;
          k = (ci << 20) | (int'(open_row[ci]) << 9) | int'(sd_addr_o[8:0]);
          v = mem_model[k];
          for (int b = 0; b < 4; b++) if (sd_be_o[b]) v[b*8 +: 8] = sd_dq_o[b*8 +: 8];
          mem_model[k] = v;
        end
        3'b010: pre_cyc = cyc;
        default: ;
      endcase
    end
  end

  task automatic access(input bit w, input logic [23:0] a, input logic [31:0] d);
    bit prot, both, got, e_seen;
    int er, n0, t_rdy, k, key, ep;
    logic [31:0] rd, m;
    er = exp_region(a, w, prot, both);
    n0 = n_cmd;
    got = 0;
    @(negedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (req_ready_o) begin got = 1; break; end
    end
    t_rdy = cyc; e_seen = req_err_o; rd = req_rdata_o;
    req_valid = 0;
    chk(got, "R3", "ready returned", 32'(got), 1);
    if (!got) return;
    if (er < 0) begin
      chk(e_seen == 1'b1, prot ? "R8" : "R9", "error flag", 32'(e_seen), 1);
      chk(n_cmd == n0, prot ? "R8" : "R9", "no command on refused access", n_cmd - n0, 0);
      return;
    end
    k  = kgap(lat[er]);
    ep = w ? ((2*k > k+1) ? 2*k : k+1) : ((2*k > 2*k+1) ? 2*k : 2*k+1);
    chk(e_seen == 1'b0, "R3", "no error on good access", 32'(e_seen), 0);
    chk(n_cmd - n0 == 3, "R3", "commands per access", n_cmd - n0, 3);
    chk(act_cs == er, both ? "R2" : "R1", "selected region", act_cs, er);
    chk(act_row == a[19:9] && cmd_col == a[8:0], "R3", "row/col", {act_row, cmd_col}, {a[19:9], a[8:0]});
    chk(cmd_cyc - act_cyc == k, "R4", "act to rd/wr", cmd_cyc - act_cyc, k);
    chk(pre_cyc - act_cyc == ep, "R6", "act to pre", pre_cyc - act_cyc, ep);
    chk(t_rdy == pre_cyc, "R5", "ready with pre", t_rdy, pre_cyc);
    chk(be_seen == lbe(ps[er]), "R10", "byte enables", 32'(be_seen), 32'(lbe(ps[er])));
    if (have_prev)
      chk(act_cyc - prev_pre >= prev_trp, "R7", "pre to act", act_cyc - prev_pre, prev_trp);
    have_prev = 1; prev_pre = pre_cyc; prev_trp = k;
    key = (er << 20) | int'(a[19:0]);
    m = lmask(ps[er]);
    if (w) begin
      chk(wr_oe && wr_dq == d, "R12", "write data with oe", wr_dq, d);
      ref_mem[key] = (ref_mem[key] & ~m) | (d & m);
    end else begin
      chk(rd == (ref_mem[key] & m), "R5", "read data", rd, ref_mem[key] & m);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E));
    base[0] = 24'h000000; base[1] = 24'h100000;
    mask[0] = 24'h0FFFFF; mask[1] = 24'h0FFFFF;
    lat[0] = 2'd0; lat[1] = 2'd1; ps[0] = 2'd0; ps[1] = 2'd2;
    vld = 2'b11; wp = 2'b00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(sd_cs_no == 2'b11 && {sd_ras_no, sd_cas_no, sd_we_no} == 3'b111, "R11", "pins idle in reset",
        {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no}, 5'h1F);
    chk(!req_ready_o && !req_err_o && !sd_dq_oe_o, "R11", "ready/err/oe low in reset",
        {req_ready_o, req_err_o, sd_dq_oe_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sd_cs_no == 2'b11 && !req_ready_o, "R11", "idle after reset", {sd_cs_no, req_ready_o}, 3'b110);

    // every latency code, write then read back (R4 R5 R6 R7)
    for (int l = 0; l < 4; l++) begin
      lat[0] = 2'(l);
      access(1, 24'h000200 + 24'(l), 32'h1234_5600 + 32'(l));
      access(0, 24'h000200 + 24'(l), 0);
    end
    access(1, 24'h100404, 32'hCAFE_F00D);
    access(0, 24'h100404, 0);
    // R10 narrow port on region 0
    ps[0] = 2'd1;
    access(1, 24'h000333, 32'hFFFF_FFFF);
    access(0, 24'h000333, 0);
    ps[0] = 2'd3;
    access(0, 24'h000333, 0);
    ps[0] = 2'd0;
    // R9 unmapped
    access(0, 24'h300010, 0);
    access(1, 24'hF00010, 32'h1);
    // R8 protected region: refused, data kept
    wp = 2'b10;
    access(1, 24'h100404, 32'h0BAD_0BAD);
    access(0, 24'h100404, 0);
    wp = 2'b00;
    // R1 invalid region
    vld = 2'b10;
    access(0, 24'h000200, 0);
    vld = 2'b11;
    // R2 overlap: region 0 first, protect decided by region 0
    base[1] = 24'h000000;
    access(1, 24'h000555, 32'h5555_AAAA);
    access(0, 24'h000555, 0);
    wp = 2'b01;
    access(1, 24'h000555, 32'h0);
    vld = 2'b10;
    access(1, 24'h000555, 32'h7777_8888);
    access(0, 24'h000555, 0);
    vld = 2'b11; wp = 2'b00; base[1] = 24'h100000;

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [23:0] a;
      if (n % 40 == 0) begin
        lat[0] = 2'($urandom); lat[1] = 2'($urandom);
        ps[0] = 2'($urandom); ps[1] = 2'($urandom);
        wp = 2'($urandom % 4 == 0 ? 2 : 0);
      end
      a = {4'($urandom % 3), 11'($urandom % 4), 9'($urandom % 8)};
      access(1'($urandom), a, $urandom);
    end
    chk(oe_bad == 0, "R12", "oe outside write command", oe_bad, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule